// File: doc/BRIEF.md
# Receive Signal-Strength Sampler and Gain Control

This block is the control logic on the receive side of a radio. It holds the manual gain settings and takes readings of received signal strength. A digitized strength value from the front-end arrives on `sample_i`. The block latches that value into a 5-bit result when a measurement fires and flags the result as fresh. Measurements fire in three cases. A start-of-packet strobe starts one at once. A read of the result register starts the next one, so software can poll the idle-channel energy by reading in a loop. The third case is a queued read. A minimum interval between readings (12 µs by default) limits how often reads can start measurements.

A read that arrives before the interval has elapsed is held as one pending request. That request fires on the first cycle the interval timer is ready. Further reads made while a request is pending merge into it. A start-of-packet strobe ignores the interval, so the first reading of a packet is never lost. That strobe also satisfies any pending request and restarts the interval.

Gain is set through a 3-bit configuration write with three fields: automatic gain, low-noise amplifier (LNA) on, and attenuator on. While automatic gain is on, the manual bits have no effect and the block reports full gain. When automatic gain is off, clearing the LNA bit removes about 20 dB. Setting the attenuator bit removes a further, independent 20 dB. A 2-bit code reports the resulting gain step.

Top module: `rssi_ctl`

## Requirements
- R1: After reset, `rdata_o` is 0, `agc_en_o` is 1, `lna_en_o` is 1, `att_en_o` is 0 and `gain_code_o` is 0.
- R2: `rdata_o` bit 7 is the fresh flag, bits 6:5 are 0 and bits 4:0 hold the most recently latched sample.
- R3: When `sop_i` is high at a clock edge, that edge latches `sample_i` and sets the fresh flag, whatever the state of the interval timer.
- R4: When `rd_i` is high at an edge with no measurement, the fresh flag clears. When the interval timer is ready at that edge, the read latches `sample_i` at the same edge and the flag stays set.
- R5: A read that arrives while the interval is running queues one measurement. It fires exactly GAP_CYC edges after the previous measurement and never earlier.
- R6: Any number of reads while a measurement is pending yield exactly one measurement.
- R7: A start-of-packet measurement cancels a pending read request. No second measurement follows it.
- R8: A configuration write (`wr_i`) stores `wdata_i` with bit 0 = automatic gain, bit 1 = LNA on and bit 2 = attenuator on. While bit 0 is 1, the outputs are `agc_en_o`=1, `lna_en_o`=1, `att_en_o`=0 and `gain_code_o`=0.
- R9: With automatic gain off, `lna_en_o` and `att_en_o` follow bits 1 and 2. `gain_code_o` is 0 for full gain, 1 for −20 dB and 2 for −40 dB, and equals (LNA off) + (attenuator on).
- R10: A start-of-packet measurement restarts the interval, so a read made after it is served GAP_CYC edges after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 5 | Digitized signal strength from the front-end |
| sop_i | input | 1 | Start-of-packet strobe |
| rd_i | input | 1 | Read strobe of the result register |
| wr_i | input | 1 | Write strobe of the gain configuration |
| wdata_i | input | 3 | Gain configuration write data |
| rdata_o | output | 8 | Result register: fresh flag and strength |
| agc_en_o | output | 1 | Automatic gain enabled |
| lna_en_o | output | 1 | Effective LNA enable |
| att_en_o | output | 1 | Effective attenuator enable |
| gain_code_o | output | 2 | Effective gain step |

## Verification
The bench builds the block with a 10 ns clock period and an 80 ns interval, which gives GAP_CYC = 8. At the default 12 µs, the interval would be 1200 cycles. With 8, the bench can count the interval edge by edge and find the exact edge where a queued read fires. In the same short runs it can merge several reads, let a start-of-packet strobe pre-empt a queued read, and watch the restart of the interval. All eight gain configurations are swept in a table.

// File: rtl/rssi_pkg.sv
package rssi_pkg;
  localparam int RSSI_W = 5;

  typedef enum logic [1:0] {
    GAIN_FULL = 2'd0,
    GAIN_M20  = 2'd1,
    GAIN_M40  = 2'd2
  } gain_code_e;

  typedef struct packed {
    logic att;
    logic lna;
    logic agc;
  } gain_cfg_t;
endpackage

// File: rtl/rssi_gap_timer.sv
module rssi_gap_timer #(
  parameter int GAP_CYC = 1200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic ready_o
);
  localparam int CNT_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(GAP_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= RELOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);

  generate
    if (GAP_CYC > 1) begin : g_gap_chk
      // a fresh measurement must block the next one
      assert_reload_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> !ready_o);
      assert_count_bounded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= RELOAD);
    end
  endgenerate
endmodule

// File: rtl/rssi_trigger.sv
module rssi_trigger (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sop_i,
  input  logic rd_i,
  input  logic ready_i,
  output logic meas_o
);
  logic pend_q, pend_d, req;

  assign req    = rd_i | pend_q;
  // start of packet ignores the rate limit
  assign meas_o = sop_i | (req & ready_i);

  always_comb begin
    pend_d = pend_q;
    if (meas_o)    pend_d = 1'b0;
    else if (rd_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assert_pending_served_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && ready_i) |=> !pend_q);
  assert_reads_merge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && rd_i && !ready_i && !sop_i) |=> pend_q);
  assert_sop_clears_pend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_i |=> !pend_q);
endmodule

// File: rtl/rssi_gain_ctl.sv
module rssi_gain_ctl
  import rssi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] wdata_i,
  output logic       agc_en_o,
  output logic       lna_en_o,
  output logic       att_en_o,
  output logic [1:0] gain_code_o
);
  gain_cfg_t  cfg_q;
  gain_code_e code;
  logic [1:0] steps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '{att: 1'b0, lna: 1'b1, agc: 1'b1};
    else if (wr_i) cfg_q <= gain_cfg_t'(wdata_i);
  end

  // each manual 20 dB step counts once
  assign steps = {1'b0, ~cfg_q.lna} + {1'b0, cfg_q.att};

  always_comb begin
    if (cfg_q.agc) code = GAIN_FULL;
    else           code = gain_code_e'(steps);
  end

  assign agc_en_o    = cfg_q.agc;
  assign lna_en_o    = cfg_q.agc | cfg_q.lna;
  assign att_en_o    = ~cfg_q.agc & cfg_q.att;
  assign gain_code_o = code;

  assert_agc_overrides_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    agc_en_o |-> (gain_code_o == 2'd0 && lna_en_o && !att_en_o));
  assert_code_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_code_o != 2'd3);
  assert_write_lands_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (agc_en_o == $past(wdata_i[0])));
endmodule

// File: rtl/rssi_ctl.sv
module rssi_ctl
  import rssi_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int GAP_NS        = 12000,
  parameter int RD_W          = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RSSI_W-1:0] sample_i,
  input  logic              sop_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [2:0]        wdata_i,
  output logic [RD_W-1:0]   rdata_o,
  output logic              agc_en_o,
  output logic              lna_en_o,
  output logic              att_en_o,
  output logic [1:0]        gain_code_o
);
  localparam int GAP_CYC = (GAP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int PAD_W   = RD_W - RSSI_W - 1;

  logic              ready, meas;
  logic [RSSI_W-1:0] value_q;
  logic              fresh_q;

  rssi_gap_timer #(.GAP_CYC(GAP_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (meas),
    .ready_o (ready)
  );

  rssi_trigger u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sop_i   (sop_i),
    .rd_i    (rd_i),
    .ready_i (ready),
    .meas_o  (meas)
  );

  rssi_gain_ctl u_gain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .wdata_i     (wdata_i),
    .agc_en_o    (agc_en_o),
    .lna_en_o    (lna_en_o),
    .att_en_o    (att_en_o),
    .gain_code_o (gain_code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_q <= '0;
      fresh_q <= 1'b0;
    end else if (meas) begin
      value_q <= sample_i;
      fresh_q <= 1'b1;
    end else if (rd_i) begin
      fresh_q <= 1'b0;
    end
  end

  assign rdata_o = {fresh_q, {PAD_W{1'b0}}, value_q};

  assert_sop_captures_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_i |=> (fresh_q && value_q == $past(sample_i)));
  assert_read_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !sop_i && !ready) |=> !fresh_q);
  assert_value_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sop_i && !ready) |=> $stable(value_q));
endmodule

// File: tb/rssi_ctl_tb.sv
module rssi_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] sample = '0;
  logic       sop = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [2:0] wdata = '0;
  logic [7:0] rdata;
  logic       agc_en, lna_en, att_en;
  logic [1:0] gcode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rssi_ctl #(.CLK_PERIOD_NS(10), .GAP_NS(80)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sop_i(sop), .rd_i(rd),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .agc_en_o(agc_en),
    .lna_en_o(lna_en), .att_en_o(att_en), .gain_code_o(gcode)
  );

  // [2:0] wdata, [3] lna_o, [4] att_o, [6:5] code
  localparam logic [7:0] VEC [8] = '{8'h20, 8'h09, 8'h0A, 8'h0B,
                                     8'h54, 8'h0D, 8'h3E, 8'h0F};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 gain", {agc_en, lna_en, att_en, gcode}, {1'b1, 1'b1, 1'b0, 2'd0});

    // R8 R9 gain table
    for (int i = 0; i < 8; i++) begin
      wr = 1'b1; wdata = VEC[i][2:0];
      tick();
      wr = 1'b0;
      chk("R8 agc", agc_en, VEC[i][0]);
      chk("R9 lna", lna_en, VEC[i][3]);
      chk("R9 att", att_en, VEC[i][4]);
      chk("R9 code", gcode, VEC[i][6:5]);
    end

    // R3 R2 sop capture (edge E0)
    sample = 5'd5; sop = 1'b1; tick(); sop = 1'b0;
    chk("R3 sop capture", rdata, 8'h85);
    // R4 read during interval clears flag (E1)
    sample = 5'd9; rd = 1'b1; tick(); rd = 1'b0;
    chk("R4 read clears", rdata, 8'h05);
    tick();
    rd = 1'b1; tick(); rd = 1'b0; // E3, merged
    tick(4);                      // E7
    chk("R5 not early", rdata, 8'h05);
    tick();                       // E8
    chk("R5 queued fires", rdata, 8'h89);
    sample = 5'd3; tick(12);
    chk("R6 single capture", rdata, 8'h89);

    // R4 read while ready
    rd = 1'b1; tick(); rd = 1'b0;
    chk("R4 read ready", rdata, 8'h83);

    // R10 sop restarts interval (S)
    tick(10);
    sample = 5'd17; sop = 1'b1; tick(); sop = 1'b0;
    chk("R3 sop", rdata, 8'h91);
    sample = 5'd20; rd = 1'b1; tick(); rd = 1'b0; // S+1
    chk("R10 read cleared", rdata, 8'h11);
    tick(6);                                      // S+7
    chk("R10 not early", rdata, 8'h11);
    tick();                                       // S+8
    chk("R10 served", rdata, 8'h94);

    // R7 sop cancels pending
    rd = 1'b1; tick(); rd = 1'b0;                 // pending
    chk("R7 pending", rdata, 8'h14);
    sample = 5'd7; sop = 1'b1; tick(); sop = 1'b0;
    chk("R7 sop over pend", rdata, 8'h87);
    sample = 5'd2; tick(12);
    chk("R7 no extra", rdata, 8'h87);

    // R1 reset again
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    chk("R1 re-reset", {rdata, agc_en, lna_en, att_en, gcode},
        {8'h00, 1'b1, 1'b1, 1'b0, 2'd0});

    finish_run();
  end
endmodule